// File: doc/BRIEF.md
# ADC Conversion Control and Status Register

This block is the software-facing control register that sits in front of an analog-to-digital converter's sequencer. One 8-bit register holds the completion-interrupt enable and a two-bit start-source selector. It also reports whether a conversion is running, finished or paused. A software write can launch a conversion, abort the running one, or acknowledge a completion.

Hardware start pulses come from an external trigger pin and a timer. Each of these is honoured only when the selector admits that source. A software start is honoured under every selector value. When a start is accepted, the block sends a one-cycle start pulse to the sequencer. The sequencer answers later with a one-cycle completion pulse. While a transfer engine holds the sequencer paused, the sequencer drives a level-sensitive pause request. The interrupt line is the logical AND of the enable bit and the completion flag.

Top module: `adc_ctl_status`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `conv_start`, `conv_abort` and `irq` are 0.
- R2: The register bit layout is as follows: bit 7 busy, bit 6 done, bit 5 interrupt enable, bit 4 halt, bits 3:2 source select, bit 1 software start, bit 0 reserved. A write loads bits 5 and 3:2, which read back unchanged. Bits 1 and 0 always read 0, and a write to the halt bit is ignored.
- R3: With no conversion outstanding, a write with bit 1 = 1 makes `conv_start` 1 and busy 1 in the cycle after the write. A write with bit 1 = 0 starts nothing.
- R4: Source select 00 admits no hardware trigger. Bit 2 (value 01) admits `ext_trig` and bit 3 (value 10) admits `tmr_trig`, so 11 admits both. An admitted trigger pulse while idle gives `conv_start` = 1 and busy = 1 in the next cycle. A trigger that is not admitted changes nothing.
- R5: While a conversion is outstanding (busy or halt reads 1), every start request is ignored and `conv_start` stays 0.
- R6: A `conv_done` pulse clears busy and halt and sets done in the following cycle.
- R7: While a conversion is outstanding, a write with bit 7 = 0 gives `conv_abort` = 1 for one cycle, with busy and halt 0 in the next cycle. With no conversion outstanding, it gives no abort. A write with bit 7 = 1 leaves busy unchanged.
- R8: A write with bit 6 = 0 clears done. A write with bit 6 = 1 leaves it unchanged.
- R9: `irq` is 1 exactly when the interrupt enable and done both read 1.
- R10: While a conversion is outstanding and `halt_req` is 1, the next cycle reads halt 1 and busy 0. When `halt_req` returns to 0, busy reads 1 again. Halt reads 0 whenever no conversion is outstanding.
- R11: When `conv_done` and a write with bits 7 and 6 both 0 arrive in the same cycle, the completion wins: done becomes 1 and no abort pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| ext_trig | input | 1 | External trigger pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| conv_done | input | 1 | Conversion-complete pulse from the sequencer |
| halt_req | input | 1 | Pause level from the transfer engine via the sequencer |
| conv_start | output | 1 | Start pulse to the sequencer |
| conv_abort | output | 1 | Abort pulse to the sequencer |
| irq | output | 1 | Completion interrupt request |

## Verification
The hardest situation to reach is a completion pulse that lands in the same clock as a software write that both drops busy and acknowledges done. Reaching it requires a conversion that is already running, plus exact cycle alignment of the bus write and the sequencer's pulse. The stimulus table first starts a conversion from an admitted external trigger. It then places `conv_done` and the write in one vector, so both events meet in a single edge. A paused conversion is handled in the same way: `halt_req` is held over several vectors while trigger pulses are offered, which shows that a paused conversion still blocks new starts.

// File: rtl/adc_csr_pkg.sv
package adc_csr_pkg;
  localparam int CSR_W   = 8;
  localparam int SEL_W   = 2;
  localparam int B_BUSY  = 7;
  localparam int B_DONE  = 6;
  localparam int B_IE    = 5;
  localparam int B_HALT  = 4;
  localparam int B_SELLO = 2;
  localparam int B_SELHI = B_SELLO + SEL_W - 1;
  localparam int B_SWST  = 1;

  typedef struct packed {
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic             done;
  } csr_cfg_t;
endpackage

// File: rtl/adc_csr_rst_sync.sv
module adc_csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_csr_trig_arb.sv
module adc_csr_trig_arb #(
  parameter int N_HW = 2
) (
  input  logic            sw_start,
  input  logic [N_HW-1:0] hw_trig,
  input  logic [N_HW-1:0] src_sel,
  input  logic            outstanding,
  output logic            start_ok
);
  logic [N_HW-1:0] hw_gated;

  for (genvar g = 0; g < N_HW; g++) begin : g_src
    assign hw_gated[g] = hw_trig[g] & src_sel[g];
  end

  assign start_ok = ~outstanding & (sw_start | (|hw_gated));
endmodule

// File: rtl/adc_csr_seq_ctl.sv
module adc_csr_seq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic abort_req,
  input  logic conv_done,
  input  logic halt_req,
  output logic active,
  output logic halt_flag,
  output logic conv_start,
  output logic conv_abort
);
  logic active_d, active_en, halt_d, abort_ok;

  always_comb begin
    abort_ok  = abort_req & active & ~conv_done;
    active_en = start_ok | conv_done | abort_ok;
    if (start_ok)                    active_d = 1'b1;
    else if (conv_done || abort_ok)  active_d = 1'b0;
    else                             active_d = active;
    halt_d = halt_req & (active_en ? active_d : active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      halt_flag  <= 1'b0;
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
    end else begin
      if (active_en) active <= active_d;
      halt_flag  <= halt_d;
      conv_start <= start_ok;
      conv_abort <= abort_ok;
    end
  end
endmodule

// File: rtl/adc_csr_flags.sv
module adc_csr_flags
  import adc_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             conv_done,
  output csr_cfg_t         cfg,
  output logic             irq
);
  csr_cfg_t cfg_d;
  logic     done_en;

  always_comb begin
    cfg_d      = cfg;
    done_en    = conv_done | (wr_en & ~wr_data[B_DONE]);
    cfg_d.done = conv_done;
    if (wr_en) begin
      cfg_d.ie  = wr_data[B_IE];
      cfg_d.sel = wr_data[B_SELHI:B_SELLO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_en) begin
        cfg.ie  <= cfg_d.ie;
        cfg.sel <= cfg_d.sel;
      end
      if (done_en) cfg.done <= cfg_d.done;
    end
  end

  assign irq = cfg.ie & cfg.done;
endmodule

// File: rtl/adc_ctl_status.sv
module adc_ctl_status
  import adc_csr_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  output logic [CSR_W-1:0] rd_data,
  input  logic             ext_trig,
  input  logic             tmr_trig,
  input  logic             conv_done,
  input  logic             halt_req,
  output logic             conv_start,
  output logic             conv_abort,
  output logic             irq
);
  logic     srst_n, start_ok, active, halt_flag;
  csr_cfg_t cfg;

  adc_csr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  adc_csr_trig_arb #(.N_HW(SEL_W)) u_arb (
    .sw_start   (wr_en & wr_data[B_SWST]),
    .hw_trig    ({tmr_trig, ext_trig}),
    .src_sel    (cfg.sel),
    .outstanding(active),
    .start_ok   (start_ok)
  );

  adc_csr_seq_ctl u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .start_ok  (start_ok),
    .abort_req (wr_en & ~wr_data[B_BUSY]),
    .conv_done (conv_done),
    .halt_req  (halt_req),
    .active    (active),
    .halt_flag (halt_flag),
    .conv_start(conv_start),
    .conv_abort(conv_abort)
  );

  adc_csr_flags u_flags (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .conv_done(conv_done),
    .cfg      (cfg),
    .irq      (irq)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[B_BUSY]          = active & ~halt_flag;
    rd_data[B_DONE]          = cfg.done;
    rd_data[B_IE]            = cfg.ie;
    rd_data[B_HALT]          = halt_flag;
    rd_data[B_SELHI:B_SELLO] = cfg.sel;
  end
endmodule

// File: rtl/adc_csr_chk.sv
module adc_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       conv_done,
  input logic       conv_start,
  input logic       conv_abort,
  input logic       irq
);
  // R9: an interrupt needs both enable and done visible in the register
  a_r9_irq_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[6] && rd_data[5]));

  // R3, R4: an issued start leaves a conversion outstanding
  a_r3_start_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (rd_data[7] || rd_data[4]));

  // R7: an abort leaves nothing outstanding
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (!rd_data[7] && !rd_data[4]));

  // R6: completion sets the done flag on the next cycle
  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> rd_data[6]);

  // R5, R7: start and abort are never issued together
  a_r5_start_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, conv_abort}));

  // R2: the two low bits always read as zero
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00);

  // R10: busy and halt never read 1 together
  a_r10_busy_halt_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[7] && rd_data[4]));
endmodule

bind adc_ctl_status adc_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .conv_done(conv_done), .conv_start(conv_start),
  .conv_abort(conv_abort), .irq(irq)
);

// File: tb/tb_adc_ctl_status.sv
module tb_adc_ctl_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ext_trig = 1'b0, tmr_trig = 1'b0, conv_done = 1'b0, halt_req = 1'b0;
  logic [7:0] rd_data;
  logic       conv_start, conv_abort, irq;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  adc_ctl_status dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_trig(ext_trig), .tmr_trig(tmr_trig),
    .conv_done(conv_done), .halt_req(halt_req), .conv_start(conv_start),
    .conv_abort(conv_abort), .irq(irq)
  );

  // {wr_en, wr_data, ext, tmr, done, halt, exp_rd, exp_start, exp_abort, exp_irq}
  localparam int NV = 25;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 8'h2C, 4'b0000, 8'h2C, 3'b000}, // 0  R2 config, busy-0 idle no abort
    {1'b1, 8'hEE, 4'b0000, 8'hAC, 3'b100}, // 1  R3 sw start
    {1'b0, 8'h00, 4'b1000, 8'hAC, 3'b000}, // 2  R5 ext while busy
    {1'b0, 8'h00, 4'b0001, 8'h3C, 3'b000}, // 3  R10 halt
    {1'b0, 8'h00, 4'b1001, 8'h3C, 3'b000}, // 4  R5 trig while halted
    {1'b0, 8'h00, 4'b0000, 8'hAC, 3'b000}, // 5  R10 resume
    {1'b0, 8'h00, 4'b0010, 8'h6C, 3'b001}, // 6  R6 done
    {1'b0, 8'h00, 4'b0100, 8'hEC, 3'b101}, // 7  R4 timer under 11
    {1'b1, 8'h6C, 4'b0000, 8'h6C, 3'b011}, // 8  R7 abort
    {1'b1, 8'hAC, 4'b0000, 8'h2C, 3'b000}, // 9  R8 clear done
    {1'b1, 8'h24, 4'b0000, 8'h24, 3'b000}, // 10 R2 sel 01
    {1'b0, 8'h00, 4'b0100, 8'h24, 3'b000}, // 11 R4 timer blocked
    {1'b0, 8'h00, 4'b1000, 8'hA4, 3'b100}, // 12 R4 ext admitted
    {1'b1, 8'h24, 4'b0010, 8'h64, 3'b001}, // 13 R11 done beats abort
    {1'b1, 8'h28, 4'b0000, 8'h28, 3'b000}, // 14 R9 irq drops
    {1'b0, 8'h00, 4'b1000, 8'h28, 3'b000}, // 15 R4 ext blocked
    {1'b0, 8'h00, 4'b0100, 8'hA8, 3'b100}, // 16 R4 timer admitted
    {1'b0, 8'h00, 4'b0010, 8'h68, 3'b001}, // 17 R6 done
    {1'b1, 8'h00, 4'b0000, 8'h00, 3'b000}, // 18 R8 clear, R9
    {1'b0, 8'h00, 4'b1100, 8'h00, 3'b000}, // 19 R4 sel 00 blocks both
    {1'b1, 8'h82, 4'b0000, 8'h80, 3'b100}, // 20 R3 sw start, sel 00
    {1'b1, 8'h80, 4'b0000, 8'h80, 3'b000}, // 21 R7 busy-1 write no effect
    {1'b1, 8'h00, 4'b0000, 8'h00, 3'b010}, // 22 R7 abort
    {1'b1, 8'h50, 4'b0000, 8'h00, 3'b000}, // 23 R8 done-1 write, R2 halt not writable
    {1'b1, 8'h00, 4'b0000, 8'h00, 3'b000}  // 24 R7 idle no abort
  };

  function automatic string tag_of(int i);
    case (i)
      0, 10, 23: return "R2";
      1, 20:     return "R3";
      7, 11, 12, 15, 16, 19: return "R4";
      2, 4:      return "R5";
      6, 17:     return "R6";
      8, 21, 22, 24: return "R7";
      9, 18:     return "R8";
      14:        return "R9";
      3, 5:      return "R10";
      default:   return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {rd,start,abort,irq} got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {rd_data, conv_start, conv_abort, irq}, 11'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en, wr_data, ext_trig, tmr_trig, conv_done, halt_req} = VEC[i][23:11];
      @(posedge clk); #2;
      check(tag_of(i), {rd_data, conv_start, conv_abort, irq}, VEC[i][10:0]);
    end

    // R6, R9: done while idle with interrupt disabled
    @(negedge clk);
    {wr_en, ext_trig, tmr_trig, halt_req} = '0;
    conv_done = 1'b1;
    @(posedge clk); #2;
    check("R6", {rd_data, conv_start, conv_abort, irq}, {8'h40, 3'b000});
    @(negedge clk);
    conv_done = 1'b0;
    wr_en = 1'b1; wr_data = 8'h60;
    @(posedge clk); #2;
    check("R9", {rd_data, conv_start, conv_abort, irq}, {8'h60, 3'b001});

    // R1: reset in the middle of a conversion
    @(negedge clk);
    wr_data = 8'hE2;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #2;
    check("R1", {rd_data, conv_start, conv_abort, irq}, 11'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {rd_data, conv_start, conv_abort, irq}, 11'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule